// File: doc/BRIEF.md
# Edge-Kicked Watchdog Timer

This block watches a processor's activity line and raises an alarm when the line stops moving. Every change of level on `wdi_in` counts as a kick, whether the line rises or falls. A kick starts a fresh countdown of `TIMEOUT_TICKS` tick-enable cycles. If a countdown ends with no kick, the active-low output `wdo_n` drops and stays low until the next kick. The nominal timeout of 1.6 s is set by choosing the tick rate and `TIMEOUT_TICKS`.

The timer stays cleared and idle in three cases: while the system reset status `sys_rst` is high, while `wdi_driven` shows that nobody drives the activity line, and after reset until the first kick arrives. The undervoltage flag `uv_flag` pulls `wdo_n` low directly, with no minimum pulse width. With the timer idle, `wdo_n` therefore acts as a plain supply-good indicator. If `wdo_n` is to feed a manual reset input, that wiring is done outside this block.

The controller has three states. IDLE means cleared and waiting. COUNT means a countdown is running. EXPIRED means the alarm is latched. The transitions are:
- arm: IDLE to COUNT on a kick.
- restart: COUNT to COUNT on a kick, which zeroes the counter.
- expire: COUNT to EXPIRED on the terminal tick with no kick.
- recover: EXPIRED to COUNT on a kick.
- clear: any state to IDLE while `sys_rst` is high or `wdi_driven` is low.

Top module: `wdt_edge_kick`

## Requirements
- R1: While `sys_rst` is high the timer is cleared and `wdo_n` equals `!uv_flag`. After release, with no kick, `wdo_n` stays high indefinitely.
- R2: A rising or a falling change of `wdi_in` is a kick. A change set up before clock edge k is acted on at edge k+2, and it starts a full new countdown.
- R3: After `TIMEOUT_TICKS` cycles with `tick_en` high and no kick, `wdo_n` goes low right after the edge that counts the last tick.
- R4: Once low from a timeout, `wdo_n` stays low until a kick is acted on. It then returns high and a new countdown starts.
- R5: Cycles with `tick_en` low do not advance the countdown.
- R6: `uv_flag` high forces `wdo_n` low in the same cycle. When `uv_flag` drops, `wdo_n` returns high at once unless a timeout is latched.
- R7: While `wdi_driven` is low the timer is cleared and kicks are ignored, so `wdo_n` equals `!uv_flag`. After `wdi_driven` returns high, counting waits for a kick.
- R8: A kick acted on at the same edge as the terminal tick wins. The countdown restarts and `wdo_n` stays high.
- R9: A `sys_rst` pulse during a countdown cancels it. After release, no timeout occurs until a kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | System reset status, active high; clears the timer |
| tick_en | input | 1 | Timebase enable; one countdown step per high cycle |
| wdi_in | input | 1 | Asynchronous activity line from the processor |
| wdi_driven | input | 1 | High when the activity line is actively driven |
| uv_flag | input | 1 | Supply below threshold, active high |
| wdo_n | output | 1 | Watchdog expired or undervoltage, active low |

## Verification
A kick needs two synchronizer edges before the controller acts on it. The bench's reference model therefore looks back two and three samples in its own history of `wdi_in` to find a kick. An expiry appears one cycle after the edge that counts the last tick. The effect of `uv_flag` appears in the same cycle. The model advances on every rising edge, using the inputs that were driven one nanosecond after the previous edge. The output is compared at every falling edge, which sits half a period after both updates. A sweep moves the second kick across the terminal tick, so that the kick lands before, on and after the terminal count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } wdt_state_e;
endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic din,
    output logic kick
);
    // chain[0..SYNC_STAGES-1] synchronize, chain[SYNC_STAGES] holds the previous sample
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
        chain <= {chain[SYNC_STAGES-1:0], din};
    end

    assign kick = chain[SYNC_STAGES] ^ chain[SYNC_STAGES-1];
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int TIMEOUT_TICKS = 1600,
    localparam int CNT_W = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic tick_en,
    output logic terminal
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign terminal = run && tick_en && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (run && tick_en && !terminal) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST); // R3
    AST_TICK_GATED: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !clear) |=> $stable(cnt_q)); // R5
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/wdt_ctrl_fsm.sv
module wdt_ctrl_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic sys_rst,
    input  logic wdi_driven,
    input  logic kick,
    input  logic terminal,
    output logic cnt_clear,
    output logic cnt_run,
    output logic expired
);
    wdt_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!wdi_driven) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (kick) state_d = ST_COUNT;
                ST_COUNT:   if (!kick && terminal) state_d = ST_EXPIRED;
                ST_EXPIRED: if (kick) state_d = ST_COUNT;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        expired   = (state_q == ST_EXPIRED);
        cnt_run   = (state_q == ST_COUNT);
        cnt_clear = (state_q != ST_COUNT) || kick;
    end

    AST_EXPIRE: assert property (@(posedge clk) disable iff (sys_rst)
        (wdi_driven && state_q == ST_COUNT && terminal && !kick) |=> (state_q == ST_EXPIRED)); // R3
    AST_LATCHED: assert property (@(posedge clk) disable iff (sys_rst)
        (wdi_driven && state_q == ST_EXPIRED && !kick) |=> (state_q == ST_EXPIRED)); // R4
    AST_KICK_WINS: assert property (@(posedge clk) disable iff (sys_rst)
        (wdi_driven && kick && terminal) |=> (state_q == ST_COUNT)); // R8
    AST_UNDRIVEN_IDLE: assert property (@(posedge clk) disable iff (sys_rst)
        !wdi_driven |=> (state_q == ST_IDLE)); // R7
endmodule

// File: rtl/wdt_edge_kick.sv
module wdt_edge_kick #(
    parameter int TIMEOUT_TICKS = 1600,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic sys_rst,
    input  logic tick_en,
    input  logic wdi_in,
    input  logic wdi_driven,
    input  logic uv_flag,
    output logic wdo_n
);
    logic kick, terminal, cnt_clear, cnt_run, expired;

    wdt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (wdi_in),
        .kick (kick)
    );

    wdt_tick_counter #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_cnt (
        .clk      (clk),
        .rst      (sys_rst),
        .clear    (cnt_clear),
        .run      (cnt_run),
        .tick_en  (tick_en),
        .terminal (terminal)
    );

    wdt_ctrl_fsm u_fsm (
        .clk        (clk),
        .sys_rst    (sys_rst),
        .wdi_driven (wdi_driven),
        .kick       (kick),
        .terminal   (terminal),
        .cnt_clear  (cnt_clear),
        .cnt_run    (cnt_run),
        .expired    (expired)
    );

    assign wdo_n = !(expired || uv_flag);

    AST_UV_FORCES_LOW: assert property (@(posedge clk) disable iff (sys_rst)
        uv_flag |-> !wdo_n); // R6
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (sys_rst)
        ($past(sys_rst) && !uv_flag) |-> wdo_n); // R1
endmodule

// File: tb/tb_wdt_edge_kick.sv
module tb_wdt_edge_kick;
    localparam int T = 8;
    localparam int S = 2;

    logic clk = 1'b0;
    logic sys_rst = 1'b1;
    logic tick_en = 1'b1;
    logic wdi_in = 1'b0;
    logic wdi_driven = 1'b1;
    logic uv_flag = 1'b0;
    logic wdo_n;

    int total = 0;
    int bad = 0;
    string tag = "R1";
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdt_edge_kick #(.TIMEOUT_TICKS(T), .SYNC_STAGES(S)) dut (
        .clk(clk), .sys_rst(sys_rst), .tick_en(tick_en), .wdi_in(wdi_in),
        .wdi_driven(wdi_driven), .uv_flag(uv_flag), .wdo_n(wdo_n)
    );

    // reference model: 0 idle, 1 counting, 2 expired
    int m_st = 0;
    int m_cnt = 0;
    bit hist[$];

    initial begin
        for (int i = 0; i < S + 2; i++) hist.push_front(1'b0);
    end

    always @(posedge clk) begin
        bit k;
        hist.push_front(wdi_in);
        k = (hist[S] != hist[S+1]);
        while (hist.size() > S + 2) void'(hist.pop_back());
        if (sys_rst || !wdi_driven) begin
            m_st = 0; m_cnt = 0;
        end else if (m_st == 0) begin
            if (k) begin m_st = 1; m_cnt = 0; end
        end else if (m_st == 1) begin
            if (k) m_cnt = 0;
            else if (tick_en) begin
                if (m_cnt == T - 1) begin m_st = 2; m_cnt = 0; end
                else m_cnt++;
            end
        end else begin
            if (k) begin m_st = 1; m_cnt = 0; end
        end
    end

    always @(negedge clk) begin
        bit e;
        if (!done) begin
            e = !(m_st == 2) && !uv_flag;
            total++;
            if (wdo_n !== e) begin
                bad++;
                $display("FAIL %s model: wdo_n=%0b expected=%0b t=%0t", tag, wdo_n, e, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic exp);
        @(negedge clk);
        total++;
        if (wdo_n !== exp) begin
            bad++;
            $display("FAIL %s: wdo_n=%0b expected=%0b t=%0t", req, wdo_n, exp, $time);
        end
        step(1);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        bad++;
        $display("FAIL watchdog: expected=done actual=hung");
        finish_run();
    end

    initial begin
        step(10);
        tag = "R1"; chk("R1", 1'b1);
        sys_rst = 1'b0;
        step(3 * T);
        chk("R1", 1'b1);
        // R3: one rising kick, then silence
        tag = "R3";
        wdi_in = 1'b1;
        step(3 * T);
        chk("R3", 1'b0);
        // R4: latched low until a falling kick
        tag = "R4";
        step(2 * T);
        chk("R4", 1'b0);
        wdi_in = 1'b0;
        step(3);
        chk("R4", 1'b1);
        // R2: regular kicks of both polarities
        tag = "R2";
        for (int i = 0; i < 10; i++) begin
            wdi_in = ~wdi_in;
            step(T / 2);
        end
        chk("R2", 1'b1);
        // R5: tick gated half the time
        tag = "R5";
        wdi_in = ~wdi_in;
        for (int i = 0; i < 3 * T; i++) begin
            tick_en = i[0];
            step(1);
        end
        tick_en = 1'b1;
        step(2 * T);
        chk("R5", 1'b0);
        // R6: undervoltage during expired and during counting
        tag = "R6";
        uv_flag = 1'b1;
        chk("R6", 1'b0);
        wdi_in = ~wdi_in;
        step(4);
        chk("R6", 1'b0);
        uv_flag = 1'b0;
        chk("R6", 1'b1);
        // R7: undriven line ignores kicks
        tag = "R7";
        wdi_driven = 1'b0;
        for (int i = 0; i < 6; i++) begin
            wdi_in = ~wdi_in;
            step(3);
        end
        step(3 * T);
        chk("R7", 1'b1);
        wdi_driven = 1'b1;
        step(3 * T);
        chk("R7", 1'b1);
        // R8: sweep second kick across the terminal tick
        tag = "R8";
        for (int d = T - 3; d <= T + 2; d++) begin
            wdi_in = ~wdi_in;
            step(d);
            wdi_in = ~wdi_in;
            step(T + 4);
        end
        chk("R8", 1'b0);
        // R9: reset pulse mid-countdown
        tag = "R9";
        wdi_in = ~wdi_in;
        step(T / 2 + 2);
        sys_rst = 1'b1;
        step(3);
        sys_rst = 1'b0;
        step(3 * T);
        chk("R9", 1'b1);
        // R2: random activity, ticks and supply dips
        tag = "R2";
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 15) == 0) wdi_in = ~wdi_in;
            tick_en = ($urandom_range(0, 3) != 0);
            uv_flag = ($urandom_range(0, 40) == 0);
            wdi_driven = ($urandom_range(0, 200) != 0);
            step(1);
        end
        finish_run();
    end
endmodule